// File: doc/BRIEF.md
# Boundary Scan Register Chain

This block is the pin-level scan register of a test port. It places one scan cell between each device pin and the core logic. Each cell has two flip-flops. The first samples the live parallel value or takes the bit from its upstream neighbour. The second holds a value that can be driven in place of the live data. The cells form one serial path, entered at `ser_in` and left at `ser_out`. A test controller can therefore load a full pin pattern serially, snapshot live traffic without disturbing it, and then apply the loaded pattern to the pins or to the core.

The number of cells and the kind of each cell are parameters. Bit k of `OUT_MASK` set to 1 makes cell k an output cell, which sits between `core_i` and `pin_o`. A 0 makes it an input cell, which sits between `pin_i` and `core_o`. Cell 0 is next to `ser_out` and cell N_CELLS-1 takes `ser_in`. Input cells are numbered upward from cell 0 onto bits 0, 1, … of `pin_i` and `core_o`. Output cells are numbered the same way onto `core_i` and `pin_o`. Two separate mode inputs pick the held value for the output-cell group and for the input-cell group.

Top module: `bsr_chain`

## Requirements
- R1: While `rst_test_n` is low, every capture and hold flip-flop reads 0. `ser_out` is 0, and every parallel output equals its live input whatever the mode inputs are.
- R2: With `drv_pin_en` and `drv_core_en` low, each `core_o` bit equals the `pin_i` bit of the same input cell and each `pin_o` bit equals the `core_i` bit of the same output cell, within the same cycle.
- R3: A clock edge with `cap_en` high loads each input cell's capture flip-flop from its `pin_i` bit and each output cell's from its `core_i` bit.
- R4: A clock edge with `sft_en` high and `cap_en` low moves every capture bit one cell toward `ser_out` and loads cell N_CELLS-1 from `ser_in`. `ser_out` always shows cell 0's capture bit.
- R5: When `cap_en` and `sft_en` are both high, capture wins and no shift takes place.
- R6: A clock edge with `upd_en` high copies every capture bit into its hold flip-flop in the same edge. Without `upd_en` the hold flip-flops keep their value through capture and shift.
- R7: With `drv_pin_en` high, each `pin_o` bit shows the hold bit of its output cell. Input cells are not affected.
- R8: With `drv_core_en` high, each `core_o` bit shows the hold bit of its input cell. Output cells are not affected.
- R9: Capture and shift activity never changes the parallel outputs while the mode inputs are low.
- R10: Update in the same edge as a shift stores the capture bits as they were before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_test | input | 1 | Test clock; all state changes on its rising edge |
| rst_test_n | input | 1 | Asynchronous active-low test reset |
| cap_en | input | 1 | Capture strobe for the capture flip-flops |
| sft_en | input | 1 | Serial shift strobe |
| upd_en | input | 1 | Update strobe, capture to hold |
| drv_pin_en | input | 1 | Output cells drive pins from hold |
| drv_core_en | input | 1 | Input cells drive core from hold |
| ser_in | input | 1 | Serial data into cell N_CELLS-1 |
| pin_i | input | N_IN | Device input pins, one per input cell |
| core_i | input | N_OUT | Core values headed for output pins |
| ser_out | output | 1 | Serial data from cell 0 |
| pin_o | output | N_OUT | Values driven to output pins |
| core_o | output | N_IN | Values passed into the core |

## Verification
The capture and shift properties treat a strobe sampled high at a rising edge as acting on that edge. They assume the controls are stable around the edge and that capture and shift are normally mutually exclusive. The bench changes every input only on falling edges. It keeps `cap_en` and `sft_en` exclusive in its random traffic and asserts both together only in the block that checks priority. Reset is applied asynchronously from the bench, and all clocked properties are masked while it is low.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

   typedef enum logic {
      CELL_IN  = 1'b0,
      CELL_OUT = 1'b1
   } cell_kind_e;

   typedef struct packed {
      logic cap;
      logic sft;
      logic upd;
   } bsr_ctl_t;

endpackage

// File: rtl/bsr_ctl_gate.sv
module bsr_ctl_gate
   import bsr_pkg::*;
(
   input  logic     rst_n,
   input  logic     cap_en,
   input  logic     sft_en,
   input  logic     upd_en,
   input  logic     drv_pin_en,
   input  logic     drv_core_en,
   output bsr_ctl_t ctl,
   output logic     pin_sel,
   output logic     core_sel
);
   always_comb begin
      ctl.cap  = cap_en;
      ctl.sft  = sft_en & ~cap_en;
      ctl.upd  = upd_en;
      pin_sel  = drv_pin_en  & rst_n;
      core_sel = drv_core_en & rst_n;
   end
endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
   import bsr_pkg::*;
#(
   parameter logic RST_VAL = 1'b0
)(
   input  logic     clk,
   input  logic     rst_n,
   input  bsr_ctl_t ctl,
   input  logic     up_bit,
   input  logic     par_i,
   input  logic     hold_sel,
   output logic     par_o,
   output logic     cs_o,
   output logic     hold_o
);
   logic cs_q;
   logic hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_q <= RST_VAL;
      end else if (ctl.cap) begin
         cs_q <= par_i;
      end else if (ctl.sft) begin
         cs_q <= up_bit;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= RST_VAL;
      end else if (ctl.upd) begin
         hold_q <= cs_q;
      end
   end

   always_comb begin
      par_o  = hold_sel ? hold_q : par_i;
      cs_o   = cs_q;
      hold_o = hold_q;
   end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain
   import bsr_pkg::*;
#(
   parameter int                  N_CELLS  = 8,
   parameter logic [N_CELLS-1:0] OUT_MASK = 8'hA6,
   parameter logic               HOLD_RST = 1'b0,
   parameter int                  N_IN     = count_kind(N_CELLS, OUT_MASK, CELL_IN),
   parameter int                  N_OUT    = count_kind(N_CELLS, OUT_MASK, CELL_OUT)
)(
   input  logic             clk_test,
   input  logic             rst_test_n,
   input  logic             cap_en,
   input  logic             sft_en,
   input  logic             upd_en,
   input  logic             drv_pin_en,
   input  logic             drv_core_en,
   input  logic             ser_in,
   input  logic [N_IN-1:0]  pin_i,
   input  logic [N_OUT-1:0] core_i,
   output logic             ser_out,
   output logic [N_OUT-1:0] pin_o,
   output logic [N_IN-1:0]  core_o
);
   function automatic int count_kind(input int n, input logic [N_CELLS-1:0] m,
                                     input cell_kind_e k);
      int c;
      c = 0;
      for (int j = 0; j < n; j++) begin
         if (m[j] == logic'(k)) c++;
      end
      return c;
   endfunction

   function automatic int rank_of(input int pos);
      int c;
      c = 0;
      for (int j = 0; j < pos; j++) begin
         if (OUT_MASK[j] == OUT_MASK[pos]) c++;
      end
      return c;
   endfunction

   localparam int LAST = N_CELLS - 1;

   if (N_CELLS < 2 || N_IN < 1 || N_OUT < 1 ||
       N_IN + N_OUT != N_CELLS) begin : g_bad_cfg
      $error("bsr_chain: need two or more cells with at least one of each kind");
   end

   bsr_ctl_t           ctl;
   logic               pin_sel;
   logic               core_sel;
   logic [N_CELLS-1:0] cs_w;
   logic [N_CELLS-1:0] hold_w;
   logic [N_CELLS-1:0] par_in_w;
   logic [N_CELLS-1:0] par_out_w;
   logic [N_CELLS-1:0] sel_w;
   logic [N_CELLS-1:0] up_w;

   bsr_ctl_gate u_gate (
      .rst_n       (rst_test_n),
      .cap_en      (cap_en),
      .sft_en      (sft_en),
      .upd_en      (upd_en),
      .drv_pin_en  (drv_pin_en),
      .drv_core_en (drv_core_en),
      .ctl         (ctl),
      .pin_sel     (pin_sel),
      .core_sel    (core_sel)
   );

   for (genvar k = 0; k < N_CELLS; k++) begin : g_cell
      localparam int IDX = rank_of(k);

      if (k == LAST) begin : g_head
         assign up_w[k] = ser_in;
      end else begin : g_link
         assign up_w[k] = cs_w[k+1];
      end

      if (OUT_MASK[k]) begin : g_out
         assign par_in_w[k] = core_i[IDX];
         assign pin_o[IDX]  = par_out_w[k];
         assign sel_w[k]    = pin_sel;
      end else begin : g_in
         assign par_in_w[k] = pin_i[IDX];
         assign core_o[IDX] = par_out_w[k];
         assign sel_w[k]    = core_sel;
      end

      bsr_cell #(.RST_VAL(HOLD_RST)) u_cell (
         .clk      (clk_test),
         .rst_n    (rst_test_n),
         .ctl      (ctl),
         .up_bit   (up_w[k]),
         .par_i    (par_in_w[k]),
         .hold_sel (sel_w[k]),
         .par_o    (par_out_w[k]),
         .cs_o     (cs_w[k]),
         .hold_o   (hold_w[k])
      );
   end

   assign ser_out = cs_w[0];
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk #(
   parameter int                  N_CELLS  = 8,
   parameter logic [N_CELLS-1:0] OUT_MASK = 8'hA6
)(
   input logic               clk_test,
   input logic               rst_test_n,
   input logic               cap_en,
   input logic               sft_en,
   input logic               upd_en,
   input logic               drv_pin_en,
   input logic               drv_core_en,
   input logic               ser_in,
   input logic               ser_out,
   input logic [N_CELLS-1:0] cs_w,
   input logic [N_CELLS-1:0] hold_w,
   input logic [N_CELLS-1:0] par_in_w,
   input logic [N_CELLS-1:0] par_out_w
);
   AST_NORMAL_PASS: assert property (@(posedge clk_test) disable iff (!rst_test_n)
      (!drv_pin_en && !drv_core_en) |-> (par_out_w == par_in_w)); // R2

   AST_CAPTURE_LOAD: assert property (@(posedge clk_test) disable iff (!rst_test_n)
      cap_en |=> (cs_w == $past(par_in_w))); // R3

   AST_SHIFT_STEP: assert property (@(posedge clk_test) disable iff (!rst_test_n)
      (sft_en && !cap_en) |=> (cs_w == {$past(ser_in), $past(cs_w[N_CELLS-1:1])})); // R4

   AST_SERIAL_TAP: assert property (@(posedge clk_test) disable iff (!rst_test_n)
      (sft_en && !cap_en) |=> (ser_out == $past(cs_w[1]))); // R4

   AST_HOLD_KEEP: assert property (@(posedge clk_test) disable iff (!rst_test_n)
      !upd_en |=> $stable(hold_w)); // R6

   AST_HOLD_COPY: assert property (@(posedge clk_test) disable iff (!rst_test_n)
      upd_en |=> (hold_w == $past(cs_w))); // R6

   AST_PIN_DRIVE: assert property (@(posedge clk_test) disable iff (!rst_test_n)
      drv_pin_en |-> (((par_out_w ^ hold_w) & OUT_MASK) == '0)); // R7

   AST_CORE_DRIVE: assert property (@(posedge clk_test) disable iff (!rst_test_n)
      drv_core_en |-> (((par_out_w ^ hold_w) & ~OUT_MASK) == '0)); // R8

   AST_PIN_SIDE_ONLY: assert property (@(posedge clk_test) disable iff (!rst_test_n)
      !drv_core_en |-> (((par_out_w ^ par_in_w) & ~OUT_MASK) == '0)); // R7
endmodule

bind bsr_chain bsr_chain_chk #(.N_CELLS(N_CELLS), .OUT_MASK(OUT_MASK)) u_chk (
   .clk_test    (clk_test),
   .rst_test_n  (rst_test_n),
   .cap_en      (cap_en),
   .sft_en      (sft_en),
   .upd_en      (upd_en),
   .drv_pin_en  (drv_pin_en),
   .drv_core_en (drv_core_en),
   .ser_in      (ser_in),
   .ser_out     (ser_out),
   .cs_w        (cs_w),
   .hold_w      (hold_w),
   .par_in_w    (par_in_w),
   .par_out_w   (par_out_w)
);

// File: tb/sim_bsr_chain.sv
`timescale 1ns/1ps
module sim_bsr_chain;
   localparam int             N    = 8;
   localparam logic [N-1:0]   MASK = 8'hA6;
   localparam int             NI   = 4;
   localparam int             NO   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cap = 1'b0, sft = 1'b0, upd = 1'b0;
   logic          dpin = 1'b0, dcore = 1'b0, sin = 1'b0;
   logic [NI-1:0] pin_i = '0;
   logic [NO-1:0] core_i = '0;
   logic          sout;
   logic [NO-1:0] pin_o;
   logic [NI-1:0] core_o;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   bit m_cs[N];
   bit m_hold[N];
   int vidx[N];

   always #4 clk = ~clk;

   bsr_chain #(.N_CELLS(N), .OUT_MASK(MASK)) u0 (
      .clk_test(clk), .rst_test_n(rst_n), .cap_en(cap), .sft_en(sft),
      .upd_en(upd), .drv_pin_en(dpin), .drv_core_en(dcore), .ser_in(sin),
      .pin_i(pin_i), .core_i(core_i), .ser_out(sout), .pin_o(pin_o),
      .core_o(core_o)
   );

   function automatic bit live_val(input int k);
      return MASK[k] ? core_i[vidx[k]] : pin_i[vidx[k]];
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < N; k++) begin
            m_cs[k] = 1'b0;
            m_hold[k] = 1'b0;
         end
      end else begin
         bit nxt[N];
         for (int k = 0; k < N; k++) begin
            if (cap)      nxt[k] = live_val(k);
            else if (sft) nxt[k] = (k == N-1) ? sin : m_cs[k+1];
            else          nxt[k] = m_cs[k];
         end
         if (upd) for (int k = 0; k < N; k++) m_hold[k] = m_cs[k];
         for (int k = 0; k < N; k++) m_cs[k] = nxt[k];
      end
   end

   task automatic check(input string tag);
      logic [NO-1:0] ep;
      logic [NI-1:0] ec;
      logic          es;
      bit            sel;
      es = rst_n ? m_cs[0] : 1'b0;
      ep = '0;
      ec = '0;
      for (int k = 0; k < N; k++) begin
         sel = rst_n && (MASK[k] ? dpin : dcore);
         if (MASK[k]) ep[vidx[k]] = sel ? m_hold[k] : live_val(k);
         else         ec[vidx[k]] = sel ? m_hold[k] : live_val(k);
      end
      compared++;
      if ({sout, pin_o, core_o} !== {es, ep, ec}) begin
         mismatched++;
         $display("FAIL %s: ser_out=%b pin_o=%b core_o=%b expected %b %b %b",
                  tag, sout, pin_o, core_o, es, ep, ec);
      end
   endtask

   task automatic tick(input string tag);
      @(negedge clk);
      #1;
      check(tag);
   endtask

   task automatic rnd_par();
      pin_i  = NI'($urandom);
      core_i = NO'($urandom);
   endtask

   initial begin
      #(8ns * 200000);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      int ni = 0;
      int no = 0;
      for (int k = 0; k < N; k++) begin
         if (MASK[k]) begin vidx[k] = no; no++; end
         else         begin vidx[k] = ni; ni++; end
      end

      // R1: reset holds normal path and zero state even with modes requested
      dpin = 1'b1; dcore = 1'b1; cap = 1'b1;
      for (int i = 0; i < 4; i++) begin rnd_par(); tick("R1"); end
      cap = 1'b0; dpin = 1'b0; dcore = 1'b0;
      rst_n = 1'b1;

      // R2: pure pass-through
      for (int i = 0; i < 6; i++) begin rnd_par(); tick("R2"); end

      // R9: capture and shift traffic with modes low
      for (int i = 0; i < 20; i++) begin
         rnd_par();
         sin = 1'($urandom);
         cap = 1'($urandom);
         sft = ~cap & 1'($urandom);
         tick("R9");
      end

      // R3: capture a known snapshot, then R4: shift it all out
      sft = 1'b0;
      pin_i = 4'b1001; core_i = 4'b0110; cap = 1'b1;
      tick("R3");
      cap = 1'b0; sft = 1'b1;
      for (int i = 0; i < N; i++) begin
         sin = 1'(i & 1);
         rnd_par();
         tick("R4");
      end

      // R5: capture wins over shift
      cap = 1'b1; sft = 1'b1;
      for (int i = 0; i < 3; i++) begin rnd_par(); sin = ~sin; tick("R5"); end
      cap = 1'b0;

      // R6: shift a pattern, update, then hold stays through more shifting
      for (int i = 0; i < N; i++) begin sin = 1'(32'h5B >> i); tick("R6"); end
      sft = 1'b0; upd = 1'b1;
      tick("R6");
      upd = 1'b0; sft = 1'b1;

      // R7: output cells drive pins from hold
      dpin = 1'b1;
      for (int i = 0; i < 8; i++) begin rnd_par(); sin = 1'($urandom); tick("R7"); end
      dpin = 1'b0;

      // R8: input cells drive core from hold
      dcore = 1'b1;
      for (int i = 0; i < 8; i++) begin rnd_par(); sin = 1'($urandom); tick("R8"); end

      // R10: update together with shift
      dpin = 1'b1; upd = 1'b1;
      for (int i = 0; i < 5; i++) begin sin = 1'($urandom); rnd_par(); tick("R10"); end
      upd = 1'b0;

      // random mixed traffic
      for (int i = 0; i < 400; i++) begin
         rnd_par();
         sin = 1'($urandom);
         cap = (($urandom % 4) == 0);
         sft = ~cap & 1'($urandom);
         upd = (($urandom % 5) == 0);
         dpin = 1'($urandom);
         dcore = 1'($urandom);
         tick("R4");
      end

      // R1: asynchronous reset mid-run
      #1 rst_n = 1'b0;
      for (int i = 0; i < 3; i++) begin rnd_par(); tick("R1"); end
      cap = 1'b0; sft = 1'b0; upd = 1'b0; dpin = 1'b0; dcore = 1'b0;
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin rnd_par(); tick("R2"); end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule